// File: doc/BRIEF.md
# Boot Image Header Validator

This block sits in the write path of a flash programmer and watches the first words of a boot image as they stream past. Each word arrives with a valid strobe and a word index. The block adds up the words of the vector table and checks the result against the stored checksum word. It also decodes the protection word that follows the table. It forwards every word one cycle later. On request, it puts the correct checksum in place of a wrong one in the forwarded stream.

The programmer pulses `sop_i` at the start of each image. The block then reports four things: a checksum warning, a protection-word error together with the position of the field at fault, a debug-lockout flag, and a reject signal. The programmer uses reject to abort the write.

A small state machine follows the checksum window. It has four states:
- `S_WAIT0` waits for word 0.
- `S_SUM` accumulates words 1 to 6 in index order.
- `S_CK` expects word 7.
- `S_OFF` means the checksum can no longer be evaluated.

Its transitions are:
- **wait→sum**: word 0 arrives.
- **sum→sum**: the expected next word arrives.
- **sum→ck**: word 6 is accumulated.
- **ck→off**: any examined word arrives; if it is word 7, the checksum is evaluated.
- **any→off**: an examined word arrives with an unexpected index.
- **any→wait**: `sop_i` is asserted.

Top module: `boot_hdr_check`

## Requirements
- R1: After reset, all flags, `reject_o` and `out_valid_o` are 0.
- R2: `out_valid_o` follows `in_valid_i` one cycle later. For every valid word, `out_data_o` carries that word's data one cycle later, unless R5 applies.
- R3: A checksum evaluation requires words 0 to 6 to arrive in index order straight after start of image, followed directly by word 7. The expected value is the two's-complement negation of the 32-bit sum of words 0 to 6. If word 7 differs from it, `cksum_bad_o` rises one cycle after word 7. An image that starts at a nonzero index, or breaks the order, is not evaluated.
- R4: `cksum_bad_o` alone never drives `reject_o`.
- R5: When `subst_en_i` is 1 and word 7 is evaluated, `out_data_o` for word 7 is the computed checksum. Every other word, and any word 7 that is not evaluated, passes through unchanged.
- R6: The word with index 8 is the protection word, and it is decoded whenever it arrives, even as the first word of a write. It holds five 2-bit fields, at bits 11:10, 13:12, 15:14, 17:16 and 19:18. A field equal to 00 or 11 sets `crp_bad_o`, and `crp_bad_o` forces `reject_o` to 1.
- R7: When `crp_bad_o` is first raised, `crp_field_o` gives k, where the lowest invalid field sits at bit 10+2k (0 to 4). Later bad protection words do not change `crp_field_o`.
- R8: If bits 19:18 of the protection word are not 10, `nodebug_o` is set. `reject_o` is then 1 unless `allow_nodebug_i` is 1. `reject_o` follows `allow_nodebug_i` in the same cycle.
- R9: All flags are sticky until a `sop_i` pulse clears them. A word presented in the same cycle as `sop_i` belongs to the new image.
- R10: Words with an index above 8 pass through without touching any flag or the checksum state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sop_i | input | 1 | Start-of-image pulse |
| in_valid_i | input | 1 | Input word valid |
| in_index_i | input | IDX_W | Word index of the input word |
| in_data_i | input | DATA_W | Input word |
| subst_en_i | input | 1 | Replace the checksum word with the computed value |
| allow_nodebug_i | input | 1 | Allow an image that locks out debug |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | DATA_W | Forwarded word |
| cksum_bad_o | output | 1 | Stored checksum mismatch (warning) |
| crp_bad_o | output | 1 | Invalid protection field seen |
| crp_field_o | output | 3 | Index of the lowest invalid field |
| nodebug_o | output | 1 | Image disables debug access |
| reject_o | output | 1 | Image must not be written |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid latency;
- the pass-through of words above index 8;
- flag stickiness and clearing on a lone start pulse;
- the reject relations with the protection and debug flags;
- the range of the field index.

Some behaviour depends on data values and on the order of words across an image, so only the directed scenarios can show it:
- the checksum arithmetic;
- substitution of word 7;
- the choice of the lowest bad field;
- skipping evaluation for writes that start mid-table.

// File: rtl/boot_hdr_pkg.sv
package boot_hdr_pkg;
    localparam int unsigned CK_IDX      = 7;
    localparam int unsigned CRP_IDX     = 8;
    localparam int unsigned FIELD_LO    = 10;
    localparam int unsigned FIELD_N     = 5;
    localparam int unsigned FIELD_SEL_W = $clog2(FIELD_N);
    localparam logic [1:0]  DBG_OK      = 2'b10;

    typedef enum logic [1:0] {
        S_WAIT0,
        S_SUM,
        S_CK,
        S_OFF
    } hdr_state_e;
endpackage

// File: rtl/boot_hdr_seq.sv
module boot_hdr_seq
    import boot_hdr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sop_i,
    input  logic              vld_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              eval_o,
    output logic [DATA_W-1:0] ck_o
);
    hdr_state_e        state_q, state_d, state_eff;
    logic [DATA_W-1:0] sum_q, sum_d;
    logic [IDX_W-1:0]  nxt_q, nxt_d;
    logic              seen;

    assign seen = vld_i && (idx_i <= IDX_W'(CRP_IDX));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_WAIT0;
            sum_q   <= '0;
            nxt_q   <= '0;
        end else begin
            state_q <= state_d;
            sum_q   <= sum_d;
            nxt_q   <= nxt_d;
        end
    end

    always_comb begin
        state_eff = sop_i ? S_WAIT0 : state_q;
        state_d   = state_eff;
        sum_d     = sop_i ? '0 : sum_q;
        nxt_d     = sop_i ? '0 : nxt_q;
        if (seen) begin
            unique case (state_eff)
                S_WAIT0: begin
                    if (idx_i == '0) begin
                        state_d = S_SUM;
                        sum_d   = data_i;
                        nxt_d   = IDX_W'(1);
                    end else begin
                        state_d = S_OFF;
                    end
                end
                S_SUM: begin
                    if (idx_i == nxt_q) begin
                        sum_d = sum_q + data_i;
                        nxt_d = nxt_q + 1'b1;
                        if (nxt_q == IDX_W'(CK_IDX - 1)) state_d = S_CK;
                    end else begin
                        state_d = S_OFF;
                    end
                end
                S_CK:  state_d = S_OFF;
                S_OFF: state_d = S_OFF;
            endcase
        end
    end

    always_comb begin
        eval_o = seen && (state_eff == S_CK) && (idx_i == IDX_W'(CK_IDX));
        ck_o   = '0 - sum_q;
    end
endmodule

// File: rtl/boot_hdr_crp.sv
module boot_hdr_crp
    import boot_hdr_pkg::*;
(
    input  logic [2*FIELD_N-1:0]   fields_i,
    output logic                   bad_o,
    output logic [FIELD_SEL_W-1:0] first_o,
    output logic                   nodebug_o
);
    logic [FIELD_N-1:0] fbad;

    for (genvar k = 0; k < FIELD_N; k++) begin : g_fld
        assign fbad[k] = (fields_i[2*k +: 2] == 2'b00) || (fields_i[2*k +: 2] == 2'b11);
    end

    always_comb begin
        first_o = '0;
        for (int k = FIELD_N - 1; k >= 0; k--) begin
            if (fbad[k]) first_o = FIELD_SEL_W'(k);
        end
    end

    assign bad_o     = |fbad;
    assign nodebug_o = fields_i[2*(FIELD_N-1) +: 2] != DBG_OK;
endmodule

// File: rtl/boot_hdr_check.sv
module boot_hdr_check
    import boot_hdr_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sop_i,
    input  logic              in_valid_i,
    input  logic [IDX_W-1:0]  in_index_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic              subst_en_i,
    input  logic              allow_nodebug_i,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o,
    output logic              cksum_bad_o,
    output logic              crp_bad_o,
    output logic [2:0]        crp_field_o,
    output logic              nodebug_o,
    output logic              reject_o
);
    logic                   eval;
    logic [DATA_W-1:0]      ck;
    logic                   is_crp, f_bad, f_nodbg;
    logic [FIELD_SEL_W-1:0] f_first;
    logic                   cks_d, crp_d, dbg_d;
    logic [2:0]             fld_d;

    boot_hdr_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .sop_i  (sop_i),
        .vld_i  (in_valid_i),
        .idx_i  (in_index_i),
        .data_i (in_data_i),
        .eval_o (eval),
        .ck_o   (ck)
    );

    boot_hdr_crp u_crp (
        .fields_i  (in_data_i[FIELD_LO +: 2*FIELD_N]),
        .bad_o     (f_bad),
        .first_o   (f_first),
        .nodebug_o (f_nodbg)
    );

    assign is_crp = in_valid_i && (in_index_i == IDX_W'(CRP_IDX));

    always_comb begin
        cks_d = sop_i ? 1'b0 : cksum_bad_o;
        crp_d = sop_i ? 1'b0 : crp_bad_o;
        dbg_d = sop_i ? 1'b0 : nodebug_o;
        fld_d = sop_i ? 3'd0 : crp_field_o;
        if (eval && (ck != in_data_i)) cks_d = 1'b1;
        if (is_crp) begin
            if (f_bad && !crp_d) fld_d = 3'(f_first);
            crp_d = crp_d | f_bad;
            dbg_d = dbg_d | f_nodbg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_data_o  <= '0;
            cksum_bad_o <= 1'b0;
            crp_bad_o   <= 1'b0;
            nodebug_o   <= 1'b0;
            crp_field_o <= '0;
        end else begin
            out_valid_o <= in_valid_i;
            if (in_valid_i) out_data_o <= (eval && subst_en_i) ? ck : in_data_i;
            cksum_bad_o <= cks_d;
            crp_bad_o   <= crp_d;
            nodebug_o   <= dbg_d;
            crp_field_o <= fld_d;
        end
    end

    assign reject_o = crp_bad_o || (nodebug_o && !allow_nodebug_i);
endmodule

// File: rtl/boot_hdr_check_sva.sv
module boot_hdr_check_sva #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sop_i,
    input logic              in_valid_i,
    input logic [IDX_W-1:0]  in_index_i,
    input logic [DATA_W-1:0] in_data_i,
    input logic              allow_nodebug_i,
    input logic              out_valid_o,
    input logic [DATA_W-1:0] out_data_o,
    input logic              cksum_bad_o,
    input logic              crp_bad_o,
    input logic [2:0]        crp_field_o,
    input logic              nodebug_o,
    input logic              reject_o
);
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o); // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o); // R2
    AST_HIGH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_index_i > IDX_W'(8)) |=> (out_data_o == $past(in_data_i))); // R10
    AST_HIGH_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_index_i > IDX_W'(8) && !sop_i) |=> ($stable(cksum_bad_o) && $stable(crp_bad_o) && $stable(nodebug_o))); // R10
    AST_CRP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        crp_bad_o |-> reject_o); // R6
    AST_DBG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (nodebug_o && !allow_nodebug_i) |-> reject_o); // R8
    AST_CKS_NOREJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!crp_bad_o && (!nodebug_o || allow_nodebug_i)) |-> !reject_o); // R4
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (crp_bad_o && !sop_i) |=> crp_bad_o); // R9
    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (crp_bad_o && !sop_i) |=> $stable(crp_field_o)); // R7
    AST_SOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sop_i && !in_valid_i) |=> (!cksum_bad_o && !crp_bad_o && !nodebug_o)); // R9
    AST_FIELD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        crp_field_o <= 3'd4); // R7
endmodule

bind boot_hdr_check boot_hdr_check_sva #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_sva (
    .clk             (clk),
    .rst_n           (rst_n),
    .sop_i           (sop_i),
    .in_valid_i      (in_valid_i),
    .in_index_i      (in_index_i),
    .in_data_i       (in_data_i),
    .allow_nodebug_i (allow_nodebug_i),
    .out_valid_o     (out_valid_o),
    .out_data_o      (out_data_o),
    .cksum_bad_o     (cksum_bad_o),
    .crp_bad_o       (crp_bad_o),
    .crp_field_o     (crp_field_o),
    .nodebug_o       (nodebug_o),
    .reject_o        (reject_o)
);

// File: tb/boot_hdr_check_tb_top.sv
module boot_hdr_check_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sop_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [7:0]  in_index_i = '0;
    logic [31:0] in_data_i = '0;
    logic        subst_en_i = 1'b0;
    logic        allow_nodebug_i = 1'b0;
    logic        out_valid_o;
    logic [31:0] out_data_o;
    logic        cksum_bad_o, crp_bad_o, nodebug_o, reject_o;
    logic [2:0]  crp_field_o;

    int          n_chk = 0;
    int          n_err = 0;
    logic [31:0] img [0:8];

    always #5 clk = ~clk;

    boot_hdr_check dut_i (
        .clk(clk), .rst_n(rst_n), .sop_i(sop_i), .in_valid_i(in_valid_i),
        .in_index_i(in_index_i), .in_data_i(in_data_i), .subst_en_i(subst_en_i),
        .allow_nodebug_i(allow_nodebug_i), .out_valid_o(out_valid_o),
        .out_data_o(out_data_o), .cksum_bad_o(cksum_bad_o), .crp_bad_o(crp_bad_o),
        .crp_field_o(crp_field_o), .nodebug_o(nodebug_o), .reject_o(reject_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_crp(input logic [1:0] f0, f1, f2, f3, f4);
        return {12'h0, f4, f3, f2, f1, f0, 10'h155};
    endfunction

    task automatic put(input int idx, input logic [31:0] d);
        in_valid_i = 1'b1;
        in_index_i = 8'(idx);
        in_data_i  = d;
        @(negedge clk);
        in_valid_i = 1'b0;
    endtask

    task automatic start_img();
        sop_i = 1'b1;
        @(negedge clk);
        sop_i = 1'b0;
    endtask

    task automatic build(input logic [31:0] seed, input logic [31:0] crp);
        logic [31:0] s = 0;
        for (int i = 0; i < 7; i++) begin
            img[i] = seed * 32'(i + 3) ^ 32'h5A5A_0F0F;
            s += img[i];
        end
        img[7] = -s;
        img[8] = crp;
    endtask

    task automatic t_reset();
        chk("R1 valid", 32'(out_valid_o), 0);
        chk("R1 flags", {28'h0, cksum_bad_o, crp_bad_o, nodebug_o, reject_o}, 0);
    endtask

    task automatic t_good();
        build(32'h1234_5677, mk_crp(2'b01, 2'b10, 2'b01, 2'b10, 2'b10));
        subst_en_i = 1'b1;
        start_img();
        for (int i = 0; i < 9; i++) begin
            put(i, img[i]);
            chk("R2 valid", 32'(out_valid_o), 1);
            chk("R2 data", out_data_o, img[i]);
        end
        chk("R3 good cksum", 32'(cksum_bad_o), 0);
        chk("R6 good crp", 32'({crp_bad_o, nodebug_o, reject_o}), 0);
        @(negedge clk);
        chk("R2 idle valid", 32'(out_valid_o), 0);
    endtask

    task automatic t_bad_nosub();
        build(32'hCAFE_0001, mk_crp(2'b01, 2'b01, 2'b01, 2'b01, 2'b10));
        subst_en_i = 1'b0;
        start_img();
        for (int i = 0; i < 7; i++) put(i, img[i]);
        chk("R3 before word7", 32'(cksum_bad_o), 0);
        put(7, img[7] + 1);
        chk("R3 mismatch", 32'(cksum_bad_o), 1);
        chk("R5 no subst", out_data_o, img[7] + 1);
        chk("R4 no reject", 32'(reject_o), 0);
    endtask

    task automatic t_bad_sub();
        build(32'h0BAD_F00D, mk_crp(2'b01, 2'b01, 2'b01, 2'b01, 2'b10));
        subst_en_i = 1'b1;
        start_img();
        for (int i = 0; i < 7; i++) begin
            put(i, img[i]);
            if (i == 3) chk("R5 other word", out_data_o, img[3]);
        end
        put(7, 32'hDEAD_BEEF);
        chk("R5 substituted", out_data_o, img[7]);
        chk("R3 flag with subst", 32'(cksum_bad_o), 1);
        put(8, img[8]);
        chk("R5 word8 passes", out_data_o, img[8]);
        chk("R4 no reject", 32'(reject_o), 0);
    endtask

    task automatic t_partial();
        build(32'h7777_1111, mk_crp(2'b01, 2'b01, 2'b01, 2'b01, 2'b10));
        subst_en_i = 1'b1;
        start_img();
        for (int i = 3; i < 7; i++) put(i, img[i]);
        put(7, 32'h0000_0042);
        chk("R3 partial not eval", 32'(cksum_bad_o), 0);
        chk("R5 partial passthru", out_data_o, 32'h0000_0042);
        start_img();
        put(0, img[0]); put(2, img[2]);
        for (int i = 3; i < 7; i++) put(i, img[i]);
        put(7, 32'h0000_0042);
        chk("R3 gap not eval", 32'(cksum_bad_o), 0);
    endtask

    task automatic t_crp_one();
        allow_nodebug_i = 1'b0;
        start_img();
        put(8, mk_crp(2'b01, 2'b10, 2'b00, 2'b01, 2'b10));
        chk("R6 crp bad", 32'(crp_bad_o), 1);
        chk("R7 field idx", 32'(crp_field_o), 2);
        chk("R6 reject", 32'(reject_o), 1);
        chk("R8 debug ok", 32'(nodebug_o), 0);
        put(8, mk_crp(2'b11, 2'b10, 2'b01, 2'b01, 2'b10));
        chk("R7 field held", 32'(crp_field_o), 2);
    endtask

    task automatic t_crp_two();
        start_img();
        put(8, mk_crp(2'b01, 2'b11, 2'b10, 2'b00, 2'b10));
        chk("R7 lowest field", 32'(crp_field_o), 1);
        start_img();
        put(8, mk_crp(2'b01, 2'b01, 2'b01, 2'b01, 2'b11));
        chk("R7 top field", 32'(crp_field_o), 4);
        chk("R8 nodebug on 11", 32'(nodebug_o), 1);
    endtask

    task automatic t_nodebug();
        allow_nodebug_i = 1'b0;
        start_img();
        put(8, mk_crp(2'b01, 2'b01, 2'b01, 2'b01, 2'b01));
        chk("R8 nodebug", 32'(nodebug_o), 1);
        chk("R6 valid fields", 32'(crp_bad_o), 0);
        chk("R8 reject", 32'(reject_o), 1);
        allow_nodebug_i = 1'b1;
        #1;
        chk("R8 allowed", 32'(reject_o), 0);
        allow_nodebug_i = 1'b0;
        #1;
        chk("R8 disallowed", 32'(reject_o), 1);
    endtask

    task automatic t_high();
        start_img();
        put(9, mk_crp(2'b00, 2'b00, 2'b00, 2'b00, 2'b00));
        chk("R10 pass", out_data_o, mk_crp(2'b00, 2'b00, 2'b00, 2'b00, 2'b00));
        chk("R10 no flag", 32'({cksum_bad_o, crp_bad_o, nodebug_o}), 0);
        put(200, 32'hFFFF_FFFF);
        chk("R10 pass 200", out_data_o, 32'hFFFF_FFFF);
        chk("R10 no flag 200", 32'(reject_o), 0);
    endtask

    task automatic t_sop();
        start_img();
        put(8, mk_crp(2'b00, 2'b01, 2'b01, 2'b01, 2'b01));
        chk("R9 set", 32'({crp_bad_o, nodebug_o}), 3);
        start_img();
        chk("R9 cleared", 32'({cksum_bad_o, crp_bad_o, nodebug_o, reject_o}), 0);
        sop_i = 1'b1;
        put(8, mk_crp(2'b01, 2'b00, 2'b01, 2'b01, 2'b10));
        sop_i = 1'b0;
        chk("R9 same-cycle word", 32'(crp_bad_o), 1);
        chk("R9 same-cycle field", 32'(crp_field_o), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_good();
        t_bad_nosub();
        t_bad_sub();
        t_partial();
        t_crp_one();
        t_crp_two();
        t_nodebug();
        t_high();
        t_sop();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule